// File: doc/BRIEF.md
# Three-Wire Addressed Register Port

This block is the slave end of a three-line serial control port. The host drives a frame strobe, a serial clock and a shared data line. While the strobe is held low, each frame carries an address byte followed by a 24-bit data word. Both fields are sent least significant bit first. The address decides the direction of the data phase within the frame itself.

Two addresses load the two 24-bit control words that the block holds and presents in parallel. Two other addresses return one of two 24-bit status words supplied in parallel by the surrounding logic. For a read, the block captures the status word when the data phase begins and then drives it onto the shared line, one bit per serial clock. Any other address has no effect.

The bus lines are sampled by a system clock that runs much faster than the serial clock. Every bus event is detected as an edge on the synchronised copies of the lines.

Top module: `tw_regport`

## Requirements
- R1: A frame is the run of rising serial-clock edges seen while the strobe is low. The first 8 bits form the address and the next 24 form the data word. Both fields are least significant bit first, and the data line is sampled on rising serial-clock edges.
- R2: A complete frame at address D0h loads control word 0. A complete frame at address D2h loads control word 1. Each load takes all 24 data bits as received.
- R3: In a frame at address D1h the block returns status word 0, and at D3h it returns status word 1. The value changes on falling serial-clock edges. Bit 0 appears after the ninth falling edge, and each later falling edge advances one bit.
- R4: The returned status word is the value present on the status inputs at the ninth falling edge. A change on those inputs afterwards does not alter the bits shifted out.
- R5: A written word reaches the control outputs only after the strobe returns high. Until then the control outputs keep their earlier value, even after all 32 bits have arrived.
- R6: A frame that ends with a bit count other than 32 loads no control word.
- R7: After reset, control word 0 is 0F0000h: bits 19..16 (the reference-code field) are ones and bits 23..22 (the oscillator select) are zero. Control word 1 is 000000h.
- R8: The data output enable is high only from the ninth falling edge of a read frame until the strobe returns high. It stays low during the address phase and during every write frame.
- R9: A frame at any address other than D0h, D1h, D2h and D3h changes no control word and never enables the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Frame strobe; low while a frame is in progress |
| sclk_i | input | 1 | Serial clock from the host |
| sdata_i | input | 1 | Level seen on the shared data line |
| sdata_o | output | 1 | Value the block drives on the data line |
| sdata_oe | output | 1 | Output enable for the data line driver |
| ctrl0_o | output | 24 | Control word 0 (address D0h) |
| ctrl1_o | output | 24 | Control word 1 (address D2h) |
| stat0_i | input | 24 | Status word 0, returned at address D1h |
| stat1_i | input | 24 | Status word 1, returned at address D3h |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 24-bit words, a two-stage synchroniser and the four default addresses. Each serial clock half period lasts eight system clocks. That is long enough for every edge to pass the synchroniser and its edge detector before the next line change. Under these settings the bench can observe the enable at the ninth falling edge and hold a fully received frame before the strobe rises. It can also alter the status inputs in the middle of a read and cut frames short at several bit counts.

// File: rtl/tw_regport_pkg.sv
package tw_regport_pkg;

   localparam int TW_ADDR_W = 8;
   localparam int TW_WORD_W = 24;

   // Counter width able to hold 0 .. bits+1 (one extra value for "too long")
   function automatic int tw_cnt_width(input int bits);
      return $clog2(bits + 2);
   endfunction

endpackage

// File: rtl/tw_sync_line.sv
module tw_sync_line #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{IDLE_LVL}};
      else        pipe <= {pipe[STAGES-2:0], d_i};
   end

   assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/tw_frame_engine.sv
module tw_frame_engine
   import tw_regport_pkg::*;
#(
   parameter int AW  = TW_ADDR_W,
   parameter int DW  = TW_WORD_W,
   parameter int NWR = 2,
   parameter int NRD = 2,
   parameter logic [NWR*AW-1:0] WR_ADDRS = '0,
   parameter logic [NRD*AW-1:0] RD_ADDRS = '0,
   localparam int FRAME_BITS = AW + DW,
   localparam int CW = tw_cnt_width(FRAME_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strb_s,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic [NRD*DW-1:0] stat_i,
   output logic [DW-1:0]     wdata_o,
   output logic [NWR-1:0]    commit_o,
   output logic [AW-1:0]     addr_o,
   output logic [CW-1:0]     nbits_o,
   output logic              tx_bit_o,
   output logic              tx_en_o
);

   logic          strb_d, sclk_d;
   logic          strb_rise, sclk_rise, sclk_fall;
   logic [CW-1:0] nbits;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [DW-1:0] tx_sh;
   logic          tx_en;
   logic          rd_hit;
   logic [DW-1:0] rd_word;

   assign strb_rise = strb_s & ~strb_d;
   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;

   always_comb begin
      rd_hit  = 1'b0;
      rd_word = '0;
      for (int k = 0; k < NRD; k++) begin
         if (addr_q == RD_ADDRS[k*AW +: AW]) begin
            rd_hit  = 1'b1;
            rd_word = stat_i[k*DW +: DW];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_d <= 1'b1;
         sclk_d <= 1'b1;
         nbits  <= '0;
         addr_q <= '0;
         data_q <= '0;
         tx_sh  <= '0;
         tx_en  <= 1'b0;
      end else begin
         strb_d <= strb_s;
         sclk_d <= sclk_s;
         if (strb_s) begin
            nbits <= '0;
            tx_en <= 1'b0;
         end else begin
            if (sclk_rise) begin
               if (nbits <= CW'(FRAME_BITS)) nbits <= nbits + CW'(1);
               if (nbits < CW'(AW))
                  addr_q <= {sdat_s, addr_q[AW-1:1]};
               else if (nbits < CW'(FRAME_BITS))
                  data_q <= {sdat_s, data_q[DW-1:1]};
            end
            if (sclk_fall) begin
               if (nbits == CW'(AW) && rd_hit) begin
                  tx_sh <= rd_word;
                  tx_en <= 1'b1;
               end else if (tx_en) begin
                  tx_sh <= tx_sh >> 1;
               end
            end
         end
      end
   end

   for (genvar g = 0; g < NWR; g++) begin : g_commit
      assign commit_o[g] = strb_rise && (nbits == CW'(FRAME_BITS)) &&
                           (addr_q == WR_ADDRS[g*AW +: AW]);
   end

   assign wdata_o  = data_q;
   assign addr_o   = addr_q;
   assign nbits_o  = nbits;
   assign tx_bit_o = tx_sh[0];
   assign tx_en_o  = tx_en;

endmodule

// File: rtl/tw_ctrl_bank.sv
module tw_ctrl_bank #(
   parameter int DW   = 24,
   parameter int NREG = 2,
   parameter logic [NREG*DW-1:0] RST_VALS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NREG-1:0]   load_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [NREG*DW-1:0] regs_o
);

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        r <= RST_VALS[g*DW +: DW];
         else if (load_i[g]) r <= wdata_i;
      end
      assign regs_o[g*DW +: DW] = r;
   end

endmodule

// File: rtl/tw_regport.sv
module tw_regport
   import tw_regport_pkg::*;
#(
   parameter int          AW          = TW_ADDR_W,
   parameter int          DW          = TW_WORD_W,
   parameter int          SYNC_STAGES = 2,
   parameter logic [AW-1:0] WR0_ADDR  = 8'hD0,
   parameter logic [AW-1:0] WR1_ADDR  = 8'hD2,
   parameter logic [AW-1:0] RD0_ADDR  = 8'hD1,
   parameter logic [AW-1:0] RD1_ADDR  = 8'hD3,
   parameter logic [DW-1:0] CTRL0_RST = 24'h0F0000,
   parameter logic [DW-1:0] CTRL1_RST = 24'h000000,
   localparam int FRAME_BITS = AW + DW,
   localparam int CW = tw_cnt_width(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe_i,
   input  logic          sclk_i,
   input  logic          sdata_i,
   output logic          sdata_o,
   output logic          sdata_oe,
   output logic [DW-1:0] ctrl0_o,
   output logic [DW-1:0] ctrl1_o,
   input  logic [DW-1:0] stat0_i,
   input  logic [DW-1:0] stat1_i
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tw_regport: SYNC_STAGES must be at least 2");
   end
   if (AW < 2 || DW < 2) begin : g_bad_width
      $error("tw_regport: address and word widths must be at least 2");
   end

   logic [2:0]      raw_lines, sync_lines;
   logic            strb_lvl;
   logic [1:0]      commit;
   logic [AW-1:0]   addr_q;
   logic [CW-1:0]   nbits;
   logic [DW-1:0]   wdata;
   logic [2*DW-1:0] regs;

   assign raw_lines = {sdata_i, sclk_i, strobe_i};

   for (genvar g = 0; g < 3; g++) begin : g_sync
      tw_sync_line #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (raw_lines[g]),
         .q_o   (sync_lines[g])
      );
   end

   assign strb_lvl = sync_lines[0];

   tw_frame_engine #(
      .AW       (AW),
      .DW       (DW),
      .NWR      (2),
      .NRD      (2),
      .WR_ADDRS ({WR1_ADDR, WR0_ADDR}),
      .RD_ADDRS ({RD1_ADDR, RD0_ADDR})
   ) i_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .strb_s   (strb_lvl),
      .sclk_s   (sync_lines[1]),
      .sdat_s   (sync_lines[2]),
      .stat_i   ({stat1_i, stat0_i}),
      .wdata_o  (wdata),
      .commit_o (commit),
      .addr_o   (addr_q),
      .nbits_o  (nbits),
      .tx_bit_o (sdata_o),
      .tx_en_o  (sdata_oe)
   );

   tw_ctrl_bank #(
      .DW       (DW),
      .NREG     (2),
      .RST_VALS ({CTRL1_RST, CTRL0_RST})
   ) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (commit),
      .wdata_i (wdata),
      .regs_o  (regs)
   );

   assign ctrl0_o = regs[DW-1:0];
   assign ctrl1_o = regs[2*DW-1:DW];

endmodule

// File: rtl/tw_regport_chk.sv
module tw_regport_chk #(
   parameter int AW = 8,
   parameter int DW = 24,
   parameter int CW = 6,
   parameter logic [AW-1:0] RD0_ADDR  = 8'hD1,
   parameter logic [AW-1:0] RD1_ADDR  = 8'hD3,
   parameter logic [DW-1:0] CTRL0_RST = 24'h0F0000,
   parameter logic [DW-1:0] CTRL1_RST = 24'h000000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          strb_lvl,
   input logic [1:0]    commit,
   input logic [AW-1:0] addr_q,
   input logic [CW-1:0] nbits,
   input logic          sdata_oe,
   input logic [DW-1:0] ctrl0_o,
   input logic [DW-1:0] ctrl1_o
);

   a_r7_reset_values: assert property (@(posedge clk)
      !rst_n |=> (ctrl0_o == CTRL0_RST && ctrl1_o == CTRL1_RST));

   a_r5_ctrl0_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl0_o) |-> $past(commit[0]));

   a_r5_ctrl1_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl1_o) |-> $past(commit[1]));

   a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(commit));

   a_r8_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $past(strb_lvl) |-> !sdata_oe);

   a_r8_oe_after_address: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdata_oe) |-> (nbits == CW'(AW)));

   a_r9_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdata_oe) |-> (addr_q == RD0_ADDR || addr_q == RD1_ADDR));

   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      nbits <= CW'(AW + DW + 1));

endmodule

bind tw_regport tw_regport_chk #(
   .AW        (AW),
   .DW        (DW),
   .CW        (CW),
   .RD0_ADDR  (RD0_ADDR),
   .RD1_ADDR  (RD1_ADDR),
   .CTRL0_RST (CTRL0_RST),
   .CTRL1_RST (CTRL1_RST)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .strb_lvl (strb_lvl),
   .commit   (commit),
   .addr_q   (addr_q),
   .nbits    (nbits),
   .sdata_oe (sdata_oe),
   .ctrl0_o  (ctrl0_o),
   .ctrl1_o  (ctrl1_o)
);

// File: tb/test_tw_regport.sv
module test_tw_regport;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strobe = 1'b1;
   logic        sclk = 1'b1;
   logic        host_d = 1'b1;
   logic        host_drive = 1'b1;
   logic        bus;
   logic        sdata_o, sdata_oe;
   logic [23:0] ctrl0, ctrl1;
   logic [23:0] stat0 = '0;
   logic [23:0] stat1 = '0;

   always #10 clk = ~clk;

   assign bus = host_drive ? host_d : (sdata_oe ? sdata_o : 1'b1);

   tw_regport i_tw_regport (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe),
      .sclk_i   (sclk),
      .sdata_i  (bus),
      .sdata_o  (sdata_o),
      .sdata_oe (sdata_oe),
      .ctrl0_o  (ctrl0),
      .ctrl1_o  (ctrl1),
      .stat0_i  (stat0),
      .stat1_i  (stat1)
   );

   typedef struct {
      string       tag;
      logic [31:0] val;
   } exp_t;

   exp_t q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   // frame results
   logic [23:0] rx_word;
   logic [23:0] pre0, pre1;
   bit          oe_in_addr, oe_at9, oe_any;
   bit          late_change = 1'b0;
   logic [23:0] late_value  = '0;

   task automatic push_exp(input string tag, input logic [31:0] v);
      exp_t e;
      e.tag = tag;
      e.val = v;
      q.push_back(e);
   endtask

   // monitor: pops the oldest expectation and compares it with an observation
   task automatic monitor(input logic [31:0] actual);
      exp_t e;
      if (q.size() == 0) begin
         n_fail++;
         $display("FAIL scoreboard: empty queue, actual %h expected none", actual);
         return;
      end
      e = q.pop_front();
      n_chk++;
      if (actual !== e.val) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", e.tag, actual, e.val);
      end
   endtask

   task automatic half();
      repeat (8) @(negedge clk);
   endtask

   task automatic frame(input logic [7:0] a, input logic [23:0] d,
                        input int nb, input bit rd);
      rx_word    = '0;
      oe_in_addr = 1'b0;
      oe_at9     = 1'b0;
      oe_any     = 1'b0;
      strobe = 1'b0;
      half();
      for (int i = 0; i < nb; i++) begin
         sclk = 1'b0;
         if (i < 8) begin
            host_drive = 1'b1;
            host_d     = a[i];
         end else if (rd) begin
            host_drive = 1'b0;
         end else begin
            host_d = d[i-8];
         end
         if (late_change && i == 9) stat0 = late_value;
         half();
         if (sdata_oe) oe_any = 1'b1;
         if (i < 8 && sdata_oe) oe_in_addr = 1'b1;
         if (i == 8) oe_at9 = sdata_oe;
         if (i >= 8) rx_word[i-8] = bus;
         sclk = 1'b1;
         half();
         if (i < 8 && sdata_oe) oe_in_addr = 1'b1;
      end
      pre0 = ctrl0;
      pre1 = ctrl1;
      strobe     = 1'b1;
      host_drive = 1'b1;
      host_d     = 1'b1;
      half();
      half();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R7 reset values, R8 idle enable
      push_exp("R7 ctrl0 reset", 32'h0F0000);   monitor({8'h0, ctrl0});
      push_exp("R7 ctrl1 reset", 32'h000000);   monitor({8'h0, ctrl1});
      push_exp("R8 oe idle", 32'h0);            monitor({31'h0, sdata_oe});

      // R1/R2/R5 write control word 0
      frame(8'hD0, 24'hA5C3E1, 32, 1'b0);
      push_exp("R5 ctrl0 held before strobe end", 32'h0F0000); monitor({8'h0, pre0});
      push_exp("R2 ctrl0 written LSB first (R1)", 32'hA5C3E1); monitor({8'h0, ctrl0});
      push_exp("R8 oe low in write frame", 32'h0);             monitor({31'h0, oe_any});

      // R2 write control word 1
      frame(8'hD2, 24'h5A3C96, 32, 1'b0);
      push_exp("R5 ctrl1 held before strobe end", 32'h0);      monitor({8'h0, pre1});
      push_exp("R2 ctrl1 written", 32'h5A3C96);                monitor({8'h0, ctrl1});
      push_exp("R2 ctrl0 untouched by D2 write", 32'hA5C3E1);  monitor({8'h0, ctrl0});

      // R3 read status word 0, R8 enable timing
      stat0 = 24'h123456;
      stat1 = 24'hABCDEF;
      frame(8'hD1, 24'h0, 32, 1'b1);
      push_exp("R3 read D1 word", 32'h123456);                 monitor({8'h0, rx_word});
      push_exp("R8 oe low in address phase", 32'h0);           monitor({31'h0, oe_in_addr});
      push_exp("R8 oe high after ninth fall", 32'h1);          monitor({31'h0, oe_at9});
      push_exp("R8 oe low after strobe end", 32'h0);           monitor({31'h0, sdata_oe});

      // R3 read status word 1
      frame(8'hD3, 24'h0, 32, 1'b1);
      push_exp("R3 read D3 word", 32'hABCDEF);                 monitor({8'h0, rx_word});

      // R4 status changes after capture
      late_change = 1'b1;
      late_value  = 24'h000000;
      frame(8'hD1, 24'h0, 32, 1'b1);
      late_change = 1'b0;
      push_exp("R4 capture at ninth fall", 32'h123456);        monitor({8'h0, rx_word});

      // R9 unknown write address
      frame(8'hD4, 24'hFFFFFF, 32, 1'b0);
      push_exp("R9 ctrl0 unchanged by D4", 32'hA5C3E1);        monitor({8'h0, ctrl0});
      push_exp("R9 ctrl1 unchanged by D4", 32'h5A3C96);        monitor({8'h0, ctrl1});

      // R9 unknown read-like address
      frame(8'hD5, 24'h0, 32, 1'b1);
      push_exp("R9 no drive for D5", 32'h0);                   monitor({31'h0, oe_any});

      // R6 short and long frames
      frame(8'hD0, 24'h00000F, 20, 1'b0);
      push_exp("R6 20-bit frame ignored", 32'hA5C3E1);         monitor({8'h0, ctrl0});
      frame(8'hD2, 24'h111111, 31, 1'b0);
      push_exp("R6 31-bit frame ignored", 32'h5A3C96);         monitor({8'h0, ctrl1});
      frame(8'hD2, 24'h222222, 33, 1'b0);
      push_exp("R6 33-bit frame ignored", 32'h5A3C96);         monitor({8'h0, ctrl1});

      // R2 full write back to zero, then R1 with a sparse pattern
      frame(8'hD2, 24'h000000, 32, 1'b0);
      push_exp("R2 ctrl1 cleared", 32'h000000);                monitor({8'h0, ctrl1});
      frame(8'hD0, 24'h800001, 32, 1'b0);
      push_exp("R1 end bits land in place", 32'h800001);       monitor({8'h0, ctrl0});

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule